// File: doc/BRIEF.md
# Interrupt Request Packetizer with Per-Level Inhibit

This block gathers interrupt requests from two peripheral buses of sixteen active-low lines each and turns one pending request at a time into an upstream request/identify message. Each line is first brought into the local clock domain and inverted to active-high. It is then gated by a software enable word. Devices are wired to several lines, so software sets a device's priority by choosing which of its lines stay enabled.

The chosen line becomes a vector holding the bus number and the line number. The vector is merged with a programmed priority level and offered on a valid/ready port. Every message carries the same programmed level. After a message is accepted its level counts as outstanding. Issues snooped from peer issuers also mark their level outstanding. While the programmed level is outstanding the block offers nothing new. A status return for that level on the downstream side lifts the hold.

Top module: `irq_packetizer`

## Requirements
- R1: After reset `msg_valid` is 0 and no level is outstanding, so the first pending enabled request is offered without any status return.
- R2: A request line counts as pending only while it is driven 0. Its effect passes through two register stages: a line driven low between clock edges raises `msg_valid` on the third rising edge after that, given the level is not held.
- R3: Enable bit `b*16+i` of `cfg_enable` gates line `i` of bus `b` (bus 0 is `bus0_req_n`, bus 1 is `bus1_req_n`). A line whose enable bit is 0 is never chosen.
- R4: Among the pending enabled lines of one bus, the lowest line number is chosen.
- R5: When both buses have a pending enabled line, the bus other than the bus of the last accepted message is chosen. After reset bus 0 goes first.
- R6: `msg_vector[3:0]` is the line number, `msg_vector[4]` is the bus number (0 or 1), `msg_vector[5]` is 0. `msg_level` is the value of `cfg_level` when the message is loaded.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, the message and its level hold steady. After an edge where both are 1, `msg_valid` is 0.
- R8: An accepted message marks its level outstanding. No message is loaded while `cfg_level` is outstanding.
- R9: A snooped peer issue (`peer_issue_valid`, `peer_issue_level`) marks that level outstanding. A peer issue at `cfg_level` also blocks a load in the same cycle.
- R10: A status return (`status_ret_valid`, `status_ret_level`) clears that level. A held message is loaded on the second edge after the return is driven. If a set and a clear for one level coincide, the level stays outstanding.
- R11: Levels are tracked separately. An outstanding level does not block messages at a different programmed level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus0_req_n | input | 16 | Bus 0 interrupt request lines, active low, asynchronous |
| bus1_req_n | input | 16 | Bus 1 interrupt request lines, active low, asynchronous |
| cfg_enable | input | 32 | Line enables; bit b*16+i enables line i of bus b |
| cfg_level | input | 4 | Priority level merged into every message |
| msg_valid | output | 1 | Message offered upstream |
| msg_ready | input | 1 | Upstream accepts the offered message |
| msg_vector | output | 6 | {0, bus, line} of the chosen request |
| msg_level | output | 4 | Priority level of the offered message |
| peer_issue_valid | input | 1 | A peer issuer's message was seen |
| peer_issue_level | input | 4 | Level of the snooped peer message |
| status_ret_valid | input | 1 | Status return seen on the downstream side |
| status_ret_level | input | 4 | Level the status return clears |

## Verification
The hardest cases to reach from the ports are arbitration and priority decisions taken on a stable synchronized request set. Requests change every few cycles and pass through a two-stage synchronizer, so a load can easily catch them half-way through that pipeline. The stimulus avoids this by keeping the programmed level outstanding while it changes the random request and enable words. It waits out the synchronizer and only then sends the status return, so the next load is an exact function of known inputs. Directed cases also line up a snooped peer issue with an enable change, and a set with a clear in one cycle.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt request packetizer.
// Assumes exactly two request buses, named by a one-bit select.
package irq_pkg;
    typedef enum logic {
        BUS_A = 1'b0,
        BUS_B = 1'b1
    } bus_sel_e;
endpackage

// File: rtl/irq_sync_mask.sv
// Brings asynchronous active-low request lines into the clock domain
// through STAGES flops, inverts them to active-high and gates them with
// the enable word. Assumes the enable word is already synchronous.
module irq_sync_mask #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_n,
    input  logic [W-1:0] en,
    output logic [W-1:0] pend
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: capture the raw lines, idle value all inactive.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '1;
                    else        stg[0] <= raw_n;
                end
            end else begin : g_next
                // Later flops: pass the previous stage on.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '1;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    // Invert to active-high and apply the enables.
    always_comb pend = ~stg[STAGES-1] & en;
endmodule

// File: rtl/irq_bus_pick.sv
// Fixed-priority pick within one bus: the lowest pending line number wins.
// Assumes LINE_W is wide enough to hold LINES-1.
module irq_bus_pick #(
    parameter int LINES  = 16,
    parameter int LINE_W = 4
) (
    input  logic [LINES-1:0]  pend,
    output logic              any,
    output logic [LINE_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) idx = LINE_W'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/irq_level_track.sv
// One outstanding bit per priority level. Two set sources (own accepted
// message, snooped peer issue) and one clear source (status return).
// A set and a clear for one level in the same cycle leave the bit set.
module irq_level_track #(
    parameter int LVL_W = 4,
    localparam int NLVL = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             own_set,
    input  logic [LVL_W-1:0] own_lvl,
    input  logic             peer_set,
    input  logic [LVL_W-1:0] peer_lvl,
    input  logic             clr,
    input  logic [LVL_W-1:0] clr_lvl,
    output logic [NLVL-1:0]  busy
);
    genvar l;
    generate
        for (l = 0; l < NLVL; l++) begin : g_lvl
            logic set_hit;
            logic clr_hit;

            // Decode which events address this level.
            always_comb begin
                set_hit = (own_set  && own_lvl  == LVL_W'(l)) ||
                          (peer_set && peer_lvl == LVL_W'(l));
                clr_hit = clr && clr_lvl == LVL_W'(l);
            end

            // Hold the bit; a set overrides a coincident clear.
            always_ff @(posedge clk) begin
                if (!rst_n) busy[l] <= 1'b0;
                else        busy[l] <= set_hit | (busy[l] & ~clr_hit);
            end
        end
    endgenerate
endmodule

// File: rtl/irq_packetizer.sv
// Interrupt request packetizer. Synchronizes and masks two buses of
// active-low request lines, picks one request (lowest line within a bus,
// alternating between buses), forms {0, bus, line} plus the programmed
// level, and offers it on a valid/ready port. Loading is held while the
// programmed level is outstanding from its own or a peer's issue.
// Assumes VEC_W > LINE_W + 1 and that configuration inputs are synchronous.
module irq_packetizer #(
    parameter int LINES       = 16,
    parameter int LVL_W       = 4,
    parameter int VEC_W       = 6,
    parameter int SYNC_STAGES = 2,
    localparam int LINE_W     = $clog2(LINES),
    localparam int NLVL       = 1 << LVL_W,
    localparam int PAD_W      = VEC_W - 1 - LINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   bus0_req_n,
    input  logic [LINES-1:0]   bus1_req_n,
    input  logic [2*LINES-1:0] cfg_enable,
    input  logic [LVL_W-1:0]   cfg_level,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [VEC_W-1:0]   msg_vector,
    output logic [LVL_W-1:0]   msg_level,
    input  logic               peer_issue_valid,
    input  logic [LVL_W-1:0]   peer_issue_level,
    input  logic               status_ret_valid,
    input  logic [LVL_W-1:0]   status_ret_level
);
    import irq_pkg::*;

    logic [2*LINES-1:0] pend_all;
    logic [1:0]         bus_any;
    logic [LINE_W-1:0]  bus_idx [2];
    logic [NLVL-1:0]    lvl_busy;
    bus_sel_e           last_bus;
    bus_sel_e           pick_bus;
    logic [LINE_W-1:0]  pick_idx;
    logic               hold_now;
    logic               do_load;
    logic               do_accept;

    irq_sync_mask #(
        .W      (2 * LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n ({bus1_req_n, bus0_req_n}),
        .en    (cfg_enable),
        .pend  (pend_all)
    );

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bus
            irq_bus_pick #(
                .LINES  (LINES),
                .LINE_W (LINE_W)
            ) u_pick (
                .pend (pend_all[b*LINES +: LINES]),
                .any  (bus_any[b]),
                .idx  (bus_idx[b])
            );
        end
    endgenerate

    // Alternate buses when both have work; otherwise take whichever does.
    always_comb begin
        if (bus_any[1] && (!bus_any[0] || last_bus == BUS_A)) pick_bus = BUS_B;
        else                                                  pick_bus = BUS_A;
        pick_idx = (pick_bus == BUS_B) ? bus_idx[1] : bus_idx[0];
    end

    // Load gate: idle port, some request pending, level not held.
    always_comb begin
        hold_now  = lvl_busy[cfg_level] ||
                    (peer_issue_valid && peer_issue_level == cfg_level);
        do_load   = !msg_valid && (|bus_any) && !hold_now;
        do_accept = msg_valid && msg_ready;
    end

    // Message register: load when allowed, hold until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid  <= 1'b0;
            msg_vector <= '0;
            msg_level  <= '0;
        end else if (do_load) begin
            msg_valid  <= 1'b1;
            msg_vector <= {{PAD_W{1'b0}}, pick_bus, pick_idx};
            msg_level  <= cfg_level;
        end else if (do_accept) begin
            msg_valid  <= 1'b0;
        end
    end

    // Remember the bus of the last accepted message for alternation.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_bus <= BUS_B;
        else if (do_accept) last_bus <= bus_sel_e'(msg_vector[LINE_W]);
    end

    irq_level_track #(
        .LVL_W (LVL_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_set  (do_accept),
        .own_lvl  (msg_level),
        .peer_set (peer_issue_valid),
        .peer_lvl (peer_issue_level),
        .clr      (status_ret_valid),
        .clr_lvl  (status_ret_level),
        .busy     (lvl_busy)
    );
endmodule

// File: rtl/irq_packetizer_chk.sv
// Property checker for irq_packetizer, attached with bind. Observes the
// port handshake against the per-level outstanding bits.
module irq_packetizer_chk #(
    parameter int LVL_W = 4,
    parameter int VEC_W = 6,
    localparam int NLVL = 1 << LVL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [VEC_W-1:0] msg_vector,
    input logic [LVL_W-1:0] msg_level,
    input logic             peer_issue_valid,
    input logic [LVL_W-1:0] peer_issue_level,
    input logic             status_ret_valid,
    input logic [LVL_W-1:0] status_ret_level,
    input logic [NLVL-1:0]  lvl_busy
);
    logic [NLVL-1:0] busy_q;

    // Previous-cycle copy of the outstanding bits.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= lvl_busy;
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_level));

    a_r7_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    a_r8_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !busy_q[msg_level]);

    a_r8_accept_marks: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> lvl_busy[$past(msg_level)]);

    a_r9_peer_marks: assert property (@(posedge clk) disable iff (!rst_n)
        peer_issue_valid |=> lvl_busy[$past(peer_issue_level)]);

    a_r10_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
        status_ret_valid
        && !(msg_valid && msg_ready && msg_level == status_ret_level)
        && !(peer_issue_valid && peer_issue_level == status_ret_level)
        |=> !lvl_busy[$past(status_ret_level)]);

    a_r6_vector_pad: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_vector[VEC_W-1] == 1'b0);
endmodule

bind irq_packetizer irq_packetizer_chk #(
    .LVL_W (LVL_W),
    .VEC_W (VEC_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .msg_valid        (msg_valid),
    .msg_ready        (msg_ready),
    .msg_vector       (msg_vector),
    .msg_level        (msg_level),
    .peer_issue_valid (peer_issue_valid),
    .peer_issue_level (peer_issue_level),
    .status_ret_valid (status_ret_valid),
    .status_ret_level (status_ret_level),
    .lvl_busy         (lvl_busy)
);

// File: tb/irq_packetizer_bench.sv
// Bench for irq_packetizer: directed corner cases, then seeded random
// request/enable patterns released one at a time by status returns.
module irq_packetizer_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus0_req_n = '1;
    logic [15:0] bus1_req_n = '1;
    logic [31:0] cfg_enable = '0;
    logic [3:0]  cfg_level = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [5:0]  msg_vector;
    logic [3:0]  msg_level;
    logic        peer_issue_valid = 1'b0;
    logic [3:0]  peer_issue_level = '0;
    logic        status_ret_valid = 1'b0;
    logic [3:0]  status_ret_level = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic last_bus = 1'b1;

    always #2.5 clk = ~clk;

    irq_packetizer u_irq_packetizer (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus0_req_n       (bus0_req_n),
        .bus1_req_n       (bus1_req_n),
        .cfg_enable       (cfg_enable),
        .cfg_level        (cfg_level),
        .msg_valid        (msg_valid),
        .msg_ready        (msg_ready),
        .msg_vector       (msg_vector),
        .msg_level        (msg_level),
        .peer_issue_valid (peer_issue_valid),
        .peer_issue_level (peer_issue_level),
        .status_ret_valid (status_ret_valid),
        .status_ret_level (status_ret_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected pick from raw inputs: returns {found, vector}.
    function automatic logic [6:0] exp_pick(input logic [15:0] r0, input logic [15:0] r1,
                                            input logic [31:0] en, input logic lb);
        logic [15:0] p0;
        logic [15:0] p1;
        logic        bus;
        logic [15:0] p;
        logic [3:0]  line;
        p0 = ~r0 & en[15:0];
        p1 = ~r1 & en[31:16];
        if (p0 == 0 && p1 == 0) return 7'b0;
        if (p0 != 0 && p1 != 0) bus = ~lb;
        else                    bus = (p1 != 0);
        p = bus ? p1 : p0;
        line = 4'd0;
        for (int i = 15; i >= 0; i--) if (p[i]) line = 4'(i);
        return {1'b1, 1'b0, bus, line};
    endfunction

    // Return the level, then expect the load on the second edge.
    task automatic release_expect(input logic [3:0] lvl, input logic [6:0] exp, input string req);
        @(negedge clk);
        status_ret_valid = 1'b1;
        status_ret_level = lvl;
        @(negedge clk);
        status_ret_valid = 1'b0;
        check({req, " no load on clearing edge"}, 32'(msg_valid), 32'd0);
        @(negedge clk);
        check({req, " valid after return"}, 32'(msg_valid), 32'(exp[6]));
        if (exp[6]) begin
            check({req, " vector"}, 32'(msg_vector), 32'(exp[5:0]));
            check({req, " level"}, 32'(msg_level), 32'(cfg_level));
        end
    endtask

    // Stall for dly cycles checking stability, then accept.
    task automatic accept_msg(input int dly);
        logic [5:0] v;
        logic [3:0] l;
        v = msg_vector;
        l = msg_level;
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            check("R7 stable under stall", {22'd0, msg_valid, l, msg_vector[4:0]},
                  {22'd0, 1'b1, msg_level, v[4:0]});
        end
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        check("R7 valid drops after accept", 32'(msg_valid), 32'd0);
        last_bus = v[4];
    endtask

    task automatic idle_check(input int n, input string req);
        repeat (n) @(negedge clk);
        check(req, 32'(msg_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] e;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cfg_level = 4'd9;
        @(negedge clk);
        check("R1 idle after reset", 32'(msg_valid), 32'd0);
        cfg_enable = '1;
        idle_check(4, "R2 high lines are not requests");

        // R2 timing, R6 format, R1 first message needs no return.
        bus0_req_n[5] = 1'b0;
        @(negedge clk);
        check("R2 after first edge", 32'(msg_valid), 32'd0);
        @(negedge clk);
        check("R2 after second edge", 32'(msg_valid), 32'd0);
        @(negedge clk);
        check("R2 valid on third edge", 32'(msg_valid), 32'd1);
        check("R6 vector bus0 line5", 32'(msg_vector), 32'h05);
        check("R6 level", 32'(msg_level), 32'd9);
        accept_msg(2);
        idle_check(5, "R8 held while level outstanding");

        // R11: another level is free.
        cfg_level = 4'd3;
        @(negedge clk);
        check("R11 other level loads", 32'(msg_valid), 32'd1);
        check("R11 level value", 32'(msg_level), 32'd3);
        accept_msg(0);

        // R10: set and clear together leave the level held.
        @(negedge clk);
        status_ret_valid = 1'b1; status_ret_level = 4'd3;
        peer_issue_valid = 1'b1; peer_issue_level = 4'd3;
        @(negedge clk);
        status_ret_valid = 1'b0; peer_issue_valid = 1'b0;
        idle_check(4, "R10 set wins over clear");
        release_expect(4'd3, 7'h45, "R10");
        accept_msg(1);

        // R3/R4/R5: line 2 of bus0 disabled, both buses pending.
        bus0_req_n[2] = 1'b0; bus0_req_n[7] = 1'b0;
        bus1_req_n[12] = 1'b0; bus1_req_n[1] = 1'b0;
        cfg_enable[2] = 1'b0;
        idle_check(4, "R8 held during setup");
        release_expect(4'd3, 7'h51, "R5 bus1 after bus0");
        accept_msg(0);
        release_expect(4'd3, 7'h45, "R3 R4 masked line skipped");
        accept_msg(0);
        release_expect(4'd3, 7'h51, "R5 alternation again");
        accept_msg(0);

        // R3: nothing enabled gives nothing; R9 peer blocks same cycle.
        cfg_enable = '0;
        release_expect(4'd3, 7'h00, "R3 all disabled");
        @(negedge clk);
        cfg_enable = '1;
        peer_issue_valid = 1'b1; peer_issue_level = 4'd3;
        @(negedge clk);
        peer_issue_valid = 1'b0;
        check("R9 peer blocks same cycle", 32'(msg_valid), 32'd0);
        idle_check(4, "R9 peer marks level");

        // Random phase: level 3 outstanding at the top of each pass.
        for (int it = 0; it < 200; it++) begin
            @(negedge clk);
            bus0_req_n = 16'($urandom) | 16'($urandom);
            bus1_req_n = 16'($urandom) | 16'($urandom);
            cfg_enable = $urandom | $urandom;
            if (($urandom % 8) == 0) bus0_req_n = '1;
            if (($urandom % 8) == 0) bus1_req_n = '1;
            if (($urandom % 10) == 0) begin bus0_req_n = '1; bus1_req_n = '1; end
            e = exp_pick(bus0_req_n, bus1_req_n, cfg_enable, last_bus);
            idle_check(4, "R8 random hold");
            release_expect(4'd3, e, "R4 R5 random pick");
            if (e[6]) begin
                accept_msg(int'($urandom % 4));
            end else begin
                @(negedge clk);
                peer_issue_valid = 1'b1; peer_issue_level = 4'd3;
                @(negedge clk);
                peer_issue_valid = 1'b0;
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule